// File: doc/BRIEF.md
# Snooping MESI Line State Controller

This block tracks the coherence state of every line of one private cache on a shared-bus multiprocessor. Each line sits in one of four states: Modified (dirty and private), Exclusive (clean and private), Shared (clean, possibly held elsewhere) or Invalid. The block keeps these states in a small register file indexed by line number. It updates them from two directions. Processor requests arrive already looked up against the tag array. Bus transactions come from other agents and are either plain reads or announcements that the other agent intends to write.

On the processor side it issues the bus command that a request needs: a fill read, a read-for-ownership or an upgrade of a shared copy. It also reports the state the line will take. On the snoop side it reports whether this cache holds the line. It asks for a write-back when the copy is dirty, and it intervenes when a dirty copy must answer another agent's read in place of stale memory. The tag array, data storage, bus arbitration and victim selection are handled elsewhere. When a snoop and a processor request hit the same line in one cycle, the snoop is applied first and the processor request acts on the result.

Top module: `mesi_line_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every line reads back as Invalid. The state encoding is Invalid=00, Shared=01, Exclusive=10, Modified=11.
- R2: A processor read that misses (the tag lookup misses, or the line is Invalid) drives bus command 01 (fill read) in that cycle. When `shared_in` is low, the line becomes Exclusive at the next clock.
- R3: A read miss with `shared_in` high drives bus command 01 and leaves the line Shared.
- R4: A processor write that misses drives bus command 10 (read-for-ownership) and leaves the line Modified, whatever the value of `shared_in`.
- R5: A write hit on an Exclusive line makes it Modified with bus command 00 (none).
- R6: A write hit on a Shared line drives bus command 11 (upgrade) and leaves the line Modified.
- R7: A read hit on a Shared, Exclusive or Modified line drives bus command 00, leaves the state unchanged and ignores `shared_in`.
- R8: A snooped read of a valid line raises `snoop_hit`. It turns Modified or Exclusive into Shared, and Shared stays Shared. Only a Modified line also raises `wb_req` and `intervene`.
- R9: A snooped intent-to-write on a valid line raises `snoop_hit` and makes the line Invalid. A Modified line also raises `wb_req`, but not `intervene`.
- R10: A snoop of either kind on an Invalid line raises no snoop output and changes no state.
- R11: When a snoop and a processor request name the same line in one cycle, the processor request acts on the state the snoop leaves. Its bus command and the final state follow from that state.
- R12: A snoop and a processor request on different lines in one cycle update both lines independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | Processor request present this cycle |
| cpu_write | input | 1 | 1 = write request, 0 = read request |
| cpu_hit | input | 1 | Tag lookup matched for the requested line |
| cpu_idx | input | IDX_W | Line index of the processor request |
| shared_in | input | 1 | Wired OR of the other caches' snoop hits, used on a read miss |
| snoop_valid | input | 1 | Another agent's bus transaction is present |
| snoop_itw | input | 1 | 1 = intent-to-write, 0 = plain read |
| snoop_idx | input | IDX_W | Line index of the snooped transaction |
| look_idx | input | IDX_W | Line index for the state lookup port |
| look_state | output | 2 | Current state of line `look_idx` |
| cpu_next_state | output | 2 | State the processor's line takes at the next clock |
| bus_cmd | output | 2 | 00 none, 01 fill read, 10 read-for-ownership, 11 upgrade |
| snoop_hit | output | 1 | This cache holds a valid copy of the snooped line |
| wb_req | output | 1 | Write back the dirty snooped line |
| intervene | output | 1 | Supply the dirty line to the reading agent instead of memory |

## Verification
The hardest situation to reach is a snoop and a processor request colliding on one line in the same cycle. The processor request must see the state the snoop leaves, not the stored state. The bench first sets a line to a known state through ordinary requests. It then applies both requests in a single vector: an intent-to-write snoop together with a write hit on an Exclusive line, and a snooped read of a Modified line together with a read hit. It then checks the bus command in that cycle and the state at the next clock. A second vector pairs a snoop on one line with a read miss on another, so that each line's result is checked on its own.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_READ = 2'b01,
    CMD_RFO  = 2'b10,
    CMD_UPGR = 2'b11
  } bus_cmd_t;

  // state a line takes after another agent's transaction
  function automatic mesi_t snoop_next(mesi_t cur, logic itw);
    if (cur == ST_I) return ST_I;
    return itw ? ST_I : ST_S;
  endfunction

  // state a line takes after a local request
  function automatic mesi_t cpu_next(mesi_t cur, logic miss, logic wr, logic shared);
    if (wr) return ST_M;
    if (miss) return shared ? ST_S : ST_E;
    return cur;
  endfunction

  // bus command a local request needs
  function automatic bus_cmd_t cpu_cmd(mesi_t cur, logic miss, logic wr);
    if (miss) return wr ? CMD_RFO : CMD_READ;
    if (wr && cur == ST_S) return CMD_UPGR;
    return CMD_NONE;
  endfunction

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_snp_idx,
  output mesi_t            rd_snp,
  input  logic [IDX_W-1:0] rd_cpu_idx,
  output mesi_t            rd_cpu,
  input  logic [IDX_W-1:0] rd_look_idx,
  output mesi_t            rd_look,
  input  logic             wr_snp_en,
  input  logic [IDX_W-1:0] wr_snp_idx,
  input  mesi_t            wr_snp_val,
  input  logic             wr_cpu_en,
  input  logic [IDX_W-1:0] wr_cpu_idx,
  input  mesi_t            wr_cpu_val,
  output mesi_t            state_all [1<<IDX_W]
);
  localparam int NUM_LINES = 1 << IDX_W;

  mesi_t line_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit_cpu, hit_snp;
    assign hit_cpu = wr_cpu_en && (wr_cpu_idx == IDX_W'(g));
    assign hit_snp = wr_snp_en && (wr_snp_idx == IDX_W'(g));
    // the processor write is computed from the post-snoop state, so it wins
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       line_q[g] <= ST_I;
      else if (hit_cpu) line_q[g] <= wr_cpu_val;
      else if (hit_snp) line_q[g] <= wr_snp_val;
    end
    assign state_all[g] = line_q[g];
  end

  assign rd_snp  = line_q[rd_snp_idx];
  assign rd_cpu  = line_q[rd_cpu_idx];
  assign rd_look = line_q[rd_look_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
(
  input  logic  snoop_valid,
  input  logic  snoop_itw,
  input  mesi_t cur,
  output logic  hit,
  output logic  wb,
  output logic  intv,
  output logic  wr_en,
  output mesi_t nxt
);
  logic dirty;

  assign dirty = (cur == ST_M);
  assign hit   = snoop_valid && (cur != ST_I);
  assign wb    = snoop_valid && dirty;
  assign intv  = snoop_valid && dirty && !snoop_itw;
  assign nxt   = snoop_next(cur, snoop_itw);
  assign wr_en = hit;

endmodule

// File: rtl/mesi_cpu_unit.sv
module mesi_cpu_unit
  import mesi_pkg::*;
(
  input  logic     cpu_valid,
  input  logic     cpu_write,
  input  logic     cpu_hit,
  input  logic     shared_in,
  input  mesi_t    cur,
  output bus_cmd_t cmd,
  output logic     wr_en,
  output mesi_t    nxt
);
  logic miss;

  assign miss  = !cpu_hit || (cur == ST_I);
  assign nxt   = cpu_next(cur, miss, cpu_write, shared_in);
  assign cmd   = cpu_valid ? cpu_cmd(cur, miss, cpu_write) : CMD_NONE;
  assign wr_en = cpu_valid;

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic             cpu_write,
  input  logic             cpu_hit,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             shared_in,
  input  logic             snoop_valid,
  input  logic             snoop_itw,
  input  logic [IDX_W-1:0] snoop_idx,
  input  logic [IDX_W-1:0] look_idx,
  output logic [1:0]       look_state,
  output logic [1:0]       cpu_next_state,
  output logic [1:0]       bus_cmd,
  output logic             snoop_hit,
  output logic             wb_req,
  output logic             intervene
);
  localparam int NUM_LINES = 1 << IDX_W;

  mesi_t    st_snp, st_cpu, st_look, snp_nxt, cpu_nxt, cpu_cur;
  mesi_t    state_all [NUM_LINES];
  logic     snp_wr, cpu_wr, same_line;
  bus_cmd_t cmd;

  mesi_state_array #(.IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_snp_idx(snoop_idx), .rd_snp(st_snp),
    .rd_cpu_idx(cpu_idx),   .rd_cpu(st_cpu),
    .rd_look_idx(look_idx), .rd_look(st_look),
    .wr_snp_en(snp_wr), .wr_snp_idx(snoop_idx), .wr_snp_val(snp_nxt),
    .wr_cpu_en(cpu_wr), .wr_cpu_idx(cpu_idx),   .wr_cpu_val(cpu_nxt),
    .state_all(state_all)
  );

  mesi_snoop_unit u_snoop (
    .snoop_valid(snoop_valid), .snoop_itw(snoop_itw), .cur(st_snp),
    .hit(snoop_hit), .wb(wb_req), .intv(intervene),
    .wr_en(snp_wr), .nxt(snp_nxt)
  );

  // a snoop on the same line is ordered ahead of the local request
  assign same_line = snoop_valid && (snoop_idx == cpu_idx);
  assign cpu_cur   = same_line ? snp_nxt : st_cpu;

  mesi_cpu_unit u_cpu (
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_hit(cpu_hit),
    .shared_in(shared_in), .cur(cpu_cur),
    .cmd(cmd), .wr_en(cpu_wr), .nxt(cpu_nxt)
  );

  assign look_state     = st_look;
  assign cpu_next_state = cpu_nxt;
  assign bus_cmd        = cmd;

  // ---------------- assertions ----------------
  logic             wr_q, itw_q, wb_q, same_q, same_wr_q;
  logic [IDX_W-1:0] cpu_idx_q, snp_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0; itw_q <= 1'b0; wb_q <= 1'b0;
      same_q <= 1'b0; same_wr_q <= 1'b0;
      cpu_idx_q <= '0; snp_idx_q <= '0;
    end else begin
      wr_q      <= cpu_valid && cpu_write;
      itw_q     <= snoop_valid && snoop_itw;
      wb_q      <= wb_req;
      same_q    <= cpu_valid && same_line;
      same_wr_q <= cpu_valid && cpu_write && same_line;
      cpu_idx_q <= cpu_idx;
      snp_idx_q <= snoop_idx;
    end
  end

  // R4 R5 R6: any local write leaves the line Modified
  p_write_ends_m_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> state_all[cpu_idx_q] == ST_M);

  // R9: intent-to-write from another agent kills the local copy
  p_itw_kills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (itw_q && !same_q) |-> state_all[snp_idx_q] == ST_I);

  // R8: after a write-back the line is no longer owned dirty
  p_wb_drops_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_q && !same_wr_q) |-> state_all[snp_idx_q] != ST_M);

  // R7: read hits on a valid copy stay off the bus
  p_silent_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_write && cpu_hit && cpu_cur != ST_I) |-> bus_cmd == 2'b00);

  // R8: intervention only ever comes from a line this cache holds
  p_intervene_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    intervene |-> (snoop_hit && wb_req));

endmodule

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb_top;
  localparam int IDX_W = 3;
  localparam int NV    = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 0, cpu_write = 0, cpu_hit = 0, shared_in = 0;
  logic snoop_valid = 0, snoop_itw = 0;
  logic [IDX_W-1:0] cpu_idx = '0, snoop_idx = '0, look_idx = '0;
  logic [1:0] look_state, cpu_next_state, bus_cmd;
  logic snoop_hit, wb_req, intervene;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  mesi_line_ctrl #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_hit(cpu_hit),
    .cpu_idx(cpu_idx), .shared_in(shared_in),
    .snoop_valid(snoop_valid), .snoop_itw(snoop_itw), .snoop_idx(snoop_idx),
    .look_idx(look_idx), .look_state(look_state),
    .cpu_next_state(cpu_next_state), .bus_cmd(bus_cmd),
    .snoop_hit(snoop_hit), .wb_req(wb_req), .intervene(intervene)
  );

  // fields: cpu v/w/hit/idx, shared, snoop v/itw/idx,
  // expected cmd/hit/wb/intervene, line to read back, its state, requirement
  function automatic logic [25:0] v(int cv, int cw, int ch, int ci, int sh,
                                    int sv, int st, int si, int cmd, int shit,
                                    int wb, int iv, int chk, int est, int rq);
    return {1'(cv), 1'(cw), 1'(ch), 3'(ci), 1'(sh), 1'(sv), 1'(st), 3'(si),
            2'(cmd), 1'(shit), 1'(wb), 1'(iv), 3'(chk), 2'(est), 4'(rq)};
  endfunction

  // states: I=0 S=1 E=2 M=3 ; cmd: 0 none 1 read 2 rfo 3 upgrade
  localparam logic [25:0] VEC [NV] = '{
    v(1,0,0,0,0, 0,0,0, 1,0,0,0, 0,2, 2),  // R2 read miss alone -> E
    v(1,0,0,1,1, 0,0,0, 1,0,0,0, 1,1, 3),  // R3 read miss shared -> S
    v(1,1,0,2,1, 0,0,0, 2,0,0,0, 2,3, 4),  // R4 write miss -> M, shared ignored
    v(1,1,1,0,0, 0,0,0, 0,0,0,0, 0,3, 5),  // R5 E write silent
    v(1,1,1,1,0, 0,0,0, 3,0,0,0, 1,3, 6),  // R6 S write upgrade
    v(1,0,1,0,1, 0,0,0, 0,0,0,0, 0,3, 7),  // R7 M read hit
    v(0,0,0,0,0, 1,0,2, 0,1,1,1, 2,1, 8),  // R8 snoop read of M
    v(1,0,1,2,0, 0,0,0, 0,0,0,0, 2,1, 7),  // R7 S read hit
    v(0,0,0,0,0, 1,1,1, 0,1,1,0, 1,0, 9),  // R9 itw on M: wb only
    v(0,0,0,0,0, 1,0,5, 0,0,0,0, 5,0,10),  // R10 snoop read on I
    v(0,0,0,0,0, 1,1,7, 0,0,0,0, 7,0,10),  // R10 itw on I
    v(1,0,0,3,0, 0,0,0, 1,0,0,0, 3,2, 2),  // R2 fill line 3
    v(0,0,0,0,0, 1,0,3, 0,1,0,0, 3,1, 8),  // R8 snoop read of E
    v(0,0,0,0,0, 1,1,3, 0,1,0,0, 3,0, 9),  // R9 itw on S
    v(1,0,0,4,1, 1,1,2, 1,1,0,0, 4,1,12),  // R12 miss on 4, itw on 2
    v(0,0,0,0,0, 0,0,0, 0,0,0,0, 2,0,12),  // R12 line 2 now I
    v(1,1,1,2,0, 0,0,0, 2,0,0,0, 2,3, 4),  // R4 hit flag but line I -> RFO
    v(1,0,0,6,0, 0,0,0, 1,0,0,0, 6,2, 2),  // R2 fill line 6 E
    v(1,1,1,6,0, 1,1,6, 2,1,0,0, 6,3,11),  // R11 itw + write same line -> RFO, M
    v(1,0,1,6,0, 1,0,6, 0,1,1,1, 6,1,11)   // R11 snoop read M + read hit -> S
  };

  task automatic check(string what, int rq, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    cpu_valid = 0; cpu_write = 0; cpu_hit = 0; shared_in = 0;
    snoop_valid = 0; snoop_itw = 0; cpu_idx = '0; snoop_idx = '0;
  endtask

  initial begin
    idle();
    // R1: lines read Invalid during reset
    #3;
    for (int i = 0; i < (1 << IDX_W); i++) begin
      look_idx = IDX_W'(i); #1;
      check("state in reset", 1, int'(look_state), 0);
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    look_idx = 3'd5; #1;
    check("state after reset", 1, int'(look_state), 0);
    check("no bus cmd after reset", 1, int'(bus_cmd), 0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] e;
      e = VEC[i];
      @(negedge clk);
      cpu_valid = e[25]; cpu_write = e[24]; cpu_hit = e[23]; cpu_idx = e[22:20];
      shared_in = e[19]; snoop_valid = e[18]; snoop_itw = e[17]; snoop_idx = e[16:14];
      #1;
      check("bus_cmd", int'(e[3:0]), int'(bus_cmd), int'(e[13:12]));
      check("snoop_hit", int'(e[3:0]), int'(snoop_hit), int'(e[11]));
      check("wb_req", int'(e[3:0]), int'(wb_req), int'(e[10]));
      check("intervene", int'(e[3:0]), int'(intervene), int'(e[9]));
      if (e[25] && e[22:20] == e[8:6])
        check("cpu_next_state", int'(e[3:0]), int'(cpu_next_state), int'(e[5:4]));
      @(posedge clk);
      @(negedge clk);
      idle();
      look_idx = e[8:6];
      #1;
      check("line state", int'(e[3:0]), int'(look_state), int'(e[5:4]));
    end

    // R1: reset in the middle of traffic clears an owned line
    @(negedge clk);
    look_idx = 3'd0; #1;
    check("line 0 owned before reset", 1, int'(look_state), 3);
    rst_n = 1'b0; #1;
    check("line 0 cleared by reset", 1, int'(look_state), 0);
    look_idx = 3'd6; #1;
    check("line 6 cleared by reset", 1, int'(look_state), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("[TB] FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule